// File: doc/BRIEF.md
# Fill/Drain Sequencer with In-State Input Synchronization

This block is a small control sequencer that runs one write burst into an external RAM each time an asynchronous fill request arrives, then waits for an asynchronous drain request before it starts over. It has no synchronizer flops in front of it. Each of its two wait states shifts the request it watches into a shared flag chain, one to three stages deep. The state register only ever decides on the last stage of that chain, so a raw asynchronous level never reaches more than one flop directly.

The fill and drain requests come from a foreign domain. Their sources must never change both at the same moment, because both share the single chain. The write enable, the write address and the read address are plain registered control outputs with no handshake. A user connects them straight to the RAM's write port and to a read pointer that advances alongside it.

Top module: `fds_seq`

## Requirements
- R1: While reset is held, `wr_en` is 0, `wr_addr` and `rd_addr` are 0, and `busy` is 0. Reset is synchronous and active high.
- R2: One clock after leaving the idle state, the sequencer enters the fill wait. `busy` is 1 in every state except idle.
- R3: In the fill wait, the sequencer leaves exactly SYNC_STAGES clock edges after the edge that first samples `fill_req` high. A pulse that rises and falls between two edges has no effect. The state never changes on the edge that samples the raw request.
- R4: `wr_en` rises on the edge that leaves the fill wait. It stays high for exactly WORDS consecutive cycles and then falls.
- R5: `wr_en` is 0 whenever the sequencer is not in its write phase. This covers idle, both waits and any unused encoding.
- R6: On every edge where `wr_en` was 1, `wr_addr` and `rd_addr` each advance by one, wrapping modulo 2^AW. On all other edges they hold.
- R7: In the drain wait, the same chain samples `drain_req`. The sequencer returns to idle exactly SYNC_STAGES edges after the edge that first samples it high. `fill_req` is ignored in the drain wait, and `drain_req` is ignored in the fill wait.
- R8: The chain is cleared when a wait state is left and in every other state. A request already high when the drain wait is entered therefore still takes SYNC_STAGES+1 cycles in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fill_req | input | 1 | Asynchronous request to start a write burst |
| drain_req | input | 1 | Asynchronous request to release the sequencer back to idle |
| wr_en | output | 1 | Registered RAM write enable |
| wr_addr | output | AW | RAM write address |
| rd_addr | output | AW | Read address, advanced with the write address |
| busy | output | 1 | High outside the idle state |

## Verification
The bench changes the requests at random points inside the clock period and measures the exit latency of each wait against SYNC_STAGES. A design that decided on the raw input, or on a middle stage of the chain, would leave early. A sub-cycle fill glitch that no edge samples must leave the sequencer waiting; a design that reacted to it would start a spurious burst. A drain request raised during the fill wait, and a fill request held through the drain wait, both probe cross-talk in the shared chain. A chain that was not cleared on exit would leave the drain wait one or more cycles early. Bursts are counted to exactly WORDS enables, and the addresses run past their wrap point.

// File: rtl/fds_pkg.sv
package fds_pkg;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_WAIT_FILL  = 2'd1,
    ST_WRITE      = 2'd2,
    ST_WAIT_DRAIN = 2'd3
  } fsm_state_t;

endpackage

// File: rtl/fds_flag_chain.sv
// Shared capture chain: stage 0 samples the selected request, later
// stages extend resolution time; the whole chain clears on clr.
module fds_flag_chain #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              din,
  output logic [STAGES-1:0] q,
  output logic              last
);

  logic [STAGES-1:0] nxt;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign nxt[g] = din;
    end else begin : g_tail
      assign nxt[g] = q[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else            q <= nxt;
  end

  assign last = q[STAGES-1];

endmodule

// File: rtl/fds_addr_ctr.sv
// Wrapping address counter that steps once per enabled clock.
module fds_addr_ctr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] addr
);

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (step) addr <= addr + 1'b1;
  end

endmodule

// File: rtl/fds_seq.sv
module fds_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int WORDS       = 8,
  parameter int AW          = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fill_req,
  input  logic          drain_req,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          busy
);
  import fds_pkg::*;

  localparam int WCW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [WCW-1:0] LAST_WORD = WCW'(WORDS - 1);

  fsm_state_t             state_q, state_d;
  logic                   wr_en_q, wr_en_d;
  logic [WCW-1:0]         word_q, word_d;
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   chain_last, chain_clr, chain_din;

  // Only the chain head sees a raw request; the mux picks which one.
  assign chain_din = (state_q == ST_WAIT_DRAIN) ? drain_req : fill_req;

  fds_flag_chain #(.STAGES(SYNC_STAGES)) u_chain (
    .clk  (clk),
    .rst  (rst),
    .clr  (chain_clr),
    .din  (chain_din),
    .q    (chain_q),
    .last (chain_last)
  );

  always_comb begin
    state_d   = state_q;
    wr_en_d   = 1'b0;
    word_d    = word_q;
    chain_clr = 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        state_d = ST_WAIT_FILL;
        word_d  = '0;
      end
      ST_WAIT_FILL: begin
        if (chain_last) begin
          state_d = ST_WRITE;
          wr_en_d = 1'b1;
          word_d  = '0;
        end else begin
          chain_clr = 1'b0;
        end
      end
      ST_WRITE: begin
        if (word_q == LAST_WORD) begin
          state_d = ST_WAIT_DRAIN;
          wr_en_d = 1'b0;
          word_d  = '0;
        end else begin
          wr_en_d = 1'b1;
          word_d  = word_q + 1'b1;
        end
      end
      ST_WAIT_DRAIN: begin
        if (chain_last) begin
          state_d = ST_IDLE;
        end else begin
          chain_clr = 1'b0;
        end
      end
      default: begin
        state_d = ST_IDLE;
        wr_en_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wr_en_q <= 1'b0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      wr_en_q <= wr_en_d;
      word_q  <= word_d;
    end
  end

  fds_addr_ctr #(.AW(AW)) u_wr_ctr (
    .clk  (clk),
    .rst  (rst),
    .step (wr_en_q),
    .addr (wr_addr)
  );

  fds_addr_ctr #(.AW(AW)) u_rd_ctr (
    .clk  (clk),
    .rst  (rst),
    .step (wr_en_q),
    .addr (rd_addr)
  );

  assign wr_en = wr_en_q;
  assign busy  = (state_q != ST_IDLE);

endmodule

// File: rtl/fds_seq_chk.sv
module fds_seq_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int WORDS       = 8,
  parameter int AW          = 4
) (
  input logic                   clk,
  input logic                   rst,
  input fds_pkg::fsm_state_t    state,
  input logic [SYNC_STAGES-1:0] chain,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic [AW-1:0]          rd_addr
);
  import fds_pkg::*;

  int we_run;
  always_ff @(posedge clk) begin
    if (rst)        we_run <= 0;
    else if (wr_en) we_run <= we_run + 1;
    else            we_run <= 0;
  end

  a_r2_idle_to_fill: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE |=> state == ST_WAIT_FILL);

  a_r3_hold_without_flag: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_FILL && !chain[SYNC_STAGES-1]) |=> state == ST_WAIT_FILL);

  a_r3_leave_on_flag: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_FILL && chain[SYNC_STAGES-1]) |=> state == ST_WRITE);

  a_r4_rise_from_fill: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> $past(state) == ST_WAIT_FILL);

  a_r4_run_cap: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> we_run < WORDS);

  a_r4_run_full: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_en) |-> we_run == WORDS);

  a_r5_we_in_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> state == ST_WRITE);

  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (wr_addr == $past(wr_addr) + 1'b1) && (rd_addr == $past(rd_addr) + 1'b1));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(wr_addr) && $stable(rd_addr));

  a_r7_drain_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_DRAIN && !chain[SYNC_STAGES-1]) |=> state == ST_WAIT_DRAIN);

  a_r8_clear_on_entry: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_DRAIN && $past(state) == ST_WRITE) |-> chain == '0);

endmodule

bind fds_seq fds_seq_chk #(
  .SYNC_STAGES (SYNC_STAGES),
  .WORDS       (WORDS),
  .AW          (AW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .state   (state_q),
  .chain   (chain_q),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .rd_addr (rd_addr)
);

// File: tb/tb_fds_seq.sv
module tb_fds_seq;
  localparam int CLK_P = 10;
  localparam int S     = 2;
  localparam int WORDS = 5;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst, fill_req, drain_req;
  logic wr_en, busy;
  logic [AW-1:0] wr_addr, rd_addr;

  always #(CLK_P/2) clk = ~clk;

  fds_seq #(.SYNC_STAGES(S), .WORDS(WORDS), .AW(AW)) dut (
    .clk(clk), .rst(rst), .fill_req(fill_req), .drain_req(drain_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  int ms = 0;
  bit m_we = 1'b0;
  int m_wa = 0, m_ra = 0, m_word = 0;
  bit hist[$];
  int edge_no = 0;
  int fill_first = -1, drain_first = -1;

  always @(posedge clk) begin
    edge_no++;
    if (rst) begin
      ms = 0; m_we = 1'b0; m_wa = 0; m_ra = 0; m_word = 0;
      hist.delete();
    end else begin
      if (m_we) begin
        m_wa = (m_wa + 1) % DEPTH;
        m_ra = (m_ra + 1) % DEPTH;
      end
      case (ms)
        0: begin ms = 1; m_we = 1'b0; fill_first = -1; end
        1: begin
          m_we = 1'b0;
          if (hist.size() >= S && hist[hist.size()-S]) begin
            ms = 2; m_we = 1'b1; m_word = 0; hist.delete(); drain_first = -1;
          end else begin
            hist.push_back(fill_req);
            if (fill_req && fill_first < 0) fill_first = edge_no;
          end
        end
        2: begin
          if (m_word == WORDS - 1) begin ms = 3; m_we = 1'b0; m_word = 0; end
          else begin m_we = 1'b1; m_word++; end
        end
        default: begin
          m_we = 1'b0;
          if (hist.size() >= S && hist[hist.size()-S]) begin
            ms = 0; hist.delete();
          end else begin
            hist.push_back(drain_req);
            if (drain_req && drain_first < 0) drain_first = edge_no;
          end
        end
      endcase
    end
  end

  // Comparison and latency measurement at the falling edge.
  bit prev_we = 1'b0, prev_busy = 1'b0, drain_pre = 1'b0;
  int run = 0, we_fall_edge = 0;

  always @(negedge clk) begin
    if (edge_no > 0) begin
      chk(wr_en === m_we, "R5 wr_en vs model", int'(wr_en), int'(m_we));
      chk(int'(wr_addr) == m_wa, "R6 wr_addr", int'(wr_addr), m_wa);
      chk(int'(rd_addr) == m_ra, "R6 rd_addr", int'(rd_addr), m_ra);
      chk(busy === (ms != 0), "R2 busy", int'(busy), int'(ms != 0));
      if (wr_en && !prev_we)
        chk(edge_no - fill_first == S, "R3 fill exit latency", edge_no - fill_first, S);
      if (wr_en) run++;
      else if (prev_we) begin
        chk(run == WORDS, "R4 burst length", run, WORDS);
        we_fall_edge = edge_no;
        run = 0;
      end
      if (!busy && prev_busy) begin
        chk(edge_no - drain_first == S, "R7 drain exit latency", edge_no - drain_first, S);
        if (drain_pre)
          chk(edge_no - we_fall_edge == S + 1, "R8 early drain dwell", edge_no - we_fall_edge, S + 1);
      end
      prev_we = wr_en;
      prev_busy = busy;
    end
  end

  task automatic at_offset();
    @(posedge clk);
    #(1 + $urandom % 8);
  endtask

  task automatic round(input bit drain_early, input bit fill_hold);
    repeat ($urandom % 4) @(posedge clk);
    at_offset();
    fill_req = 1'b1;
    if (drain_early) begin
      drain_pre = 1'b1;
      #1 drain_req = 1'b1;
    end
    do @(negedge clk); while (!wr_en);
    if (!fill_hold) begin at_offset(); fill_req = 1'b0; end
    do @(negedge clk); while (wr_en);
    if (!drain_early) begin
      repeat ($urandom % 4) @(posedge clk);
      at_offset();
      drain_req = 1'b1;
    end
    do @(negedge clk); while (busy);
    at_offset();
    drain_req = 1'b0;
    fill_req  = 1'b0;
    drain_pre = 1'b0;
  endtask

  initial begin
    rst = 1'b1; fill_req = 1'b0; drain_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wr_en === 1'b0, "R1 wr_en in reset", int'(wr_en), 0);
    chk(wr_addr == '0, "R1 wr_addr in reset", int'(wr_addr), 0);
    chk(rd_addr == '0, "R1 rd_addr in reset", int'(rd_addr), 0);
    chk(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
    @(posedge clk);
    #2 rst = 1'b0;
    // R3: a fill pulse that no edge samples must not start a burst
    repeat (3) @(posedge clk);
    #1 fill_req = 1'b1;
    #3 fill_req = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(wr_en === 1'b0 && busy === 1'b1, "R3 unsampled glitch", int'(wr_en), 0);
    end
    for (int r = 0; r < 7; r++) round(r == 3 || r == 4, r == 2);
    repeat (5) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog requirement=all actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule